// File: doc/BRIEF.md
# Shadowed Integer Register File

This block is the integer register file of a processor core: 32 entries of 64 bits, with two read ports and one write port. A fixed, sparse group of registers (8 to 14, and 25) has a second copy, used while the core runs in a privileged shadow mode. Entering or leaving that mode exchanges the live and shadow contents of every shadowed register. Leaving the mode therefore brings back the values that were live before it was entered. All other registers are one shared copy that both modes see.

The exchange is done by remapping, not by copying. A single mode bit picks which of the two copies of a shadowed register is live. The mode changes on one clock edge when a legal request arrives. A request for the mode that is already active is illegal: it is refused, flagged on the error output for one cycle, and any write presented with it is discarded. Reads are synchronous, so the memories can map onto block RAM. Register 31 is hardwired to zero.

Top module: `shadow_regfile`

## Requirements
- R1: While reset is high and in the cycle after it is released, `shadow_active` is 1 and `mode_err` is 0.
- R2: Each read port registers its address on a clock edge and presents that register's value after the same edge. A read and a write to the same register at one edge return the value held before the write.
- R3: A write with `wr_en` high stores `wr_data` into the copy of `wr_addr` that is live, and later reads of that register return it.
- R4: Only registers 8, 9, 10, 11, 12, 13, 14 and 25 have two copies. Every other register returns its last written value in both modes.
- R5: A request with `mode_req_valid` high asks for shadow mode when `mode_req` is 1 and for normal mode when it is 0. A legal request swaps the live and hidden copies of every shadowed register, so values live before an entry return after the matching exit, and the reverse.
- R6: An accepted request updates `shadow_active` on the same edge. Reads sampled on that edge use the old mapping, and reads sampled on later edges use the new one.
- R7: A write in the same cycle as an accepted request goes to the copy that is live after the change.
- R8: A request for the mode already active raises `mode_err` for exactly the next cycle and leaves `shadow_active` unchanged.
- R9: When a request is illegal, a write presented in the same cycle is discarded, so no register contents change.
- R10: Register 31 always reads 0 on both ports and ignores writes, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read port A register number |
| rd_data_a | output | 64 | Read port A data, one edge after the address |
| rd_addr_b | input | 5 | Read port B register number |
| rd_data_b | output | 64 | Read port B data, one edge after the address |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register number |
| wr_data | input | 64 | Write data |
| mode_req_valid | input | 1 | Mode change request strobe |
| mode_req | input | 1 | Requested mode: 1 shadow, 0 normal |
| shadow_active | output | 1 | Current mode, 1 when shadow mode is active |
| mode_err | output | 1 | Pulses for one cycle after a request for the mode already active |

## Verification
The bench first fills both copies with distinct values. It then probes shadowed registers, including the isolated register 25, and unshadowed neighbours such as 7, 15, 24 and 26 in both modes. A design with a wrong shadow set, or one that copies instead of swapping, would return the other mode's value for one of these. Directed cases cover the following:
- a write landing in the same cycle as an accepted request, which a design resolving the bank with the old mode would put into the hidden copy;
- a write alongside a refused request, which a lax design would commit;
- a read sampled on the switching edge, which a design that forwarded the new mode would map early;
- read-during-write ordering;
- register 31 after it has been written.

// File: rtl/srf_pkg.sv
package srf_pkg;

  localparam int MAX_REGS = 64;

  // Number of set mask bits strictly below position lim.
  function automatic int count_below(input logic [MAX_REGS-1:0] mask, input int lim);
    int n;
    n = 0;
    for (int k = 0; k < MAX_REGS; k++) begin
      if (k < lim && mask[k]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/srf_bank.sv
module srf_bank #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 64,
  parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first synchronous RAM, one write and two read ports
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/srf_mode_ctrl.sv
module srf_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_mode,
  output logic mode_q,
  output logic err_q,
  output logic next_mode,
  output logic req_bad
);

  logic req_ok;

  always_comb begin
    req_bad   = req_valid && (req_mode == mode_q);
    req_ok    = req_valid && !req_bad;
    next_mode = req_ok ? req_mode : mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      mode_q <= next_mode;
      err_q  <= req_bad;
    end
  end

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
  parameter int          NREG        = 32,
  parameter int          DATA_W      = 64,
  parameter logic [31:0] SHADOW_MASK = 32'h0200_7F00,
  parameter int          ADDR_W      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_req_valid,
  input  logic              mode_req,
  output logic              shadow_active,
  output logic              mode_err
);

  localparam int NRD = 2;
  localparam logic [srf_pkg::MAX_REGS-1:0] MASK_X = srf_pkg::MAX_REGS'(SHADOW_MASK);
  localparam int NSHD   = srf_pkg::count_below(MASK_X, NREG);
  localparam int SLOT_W = (NSHD > 1) ? $clog2(NSHD) : 1;
  localparam logic [ADDR_W-1:0] ZERO_REG = ADDR_W'(NREG - 1);

  // mode control
  logic next_mode, req_bad;

  srf_mode_ctrl u_mode (
    .clk       (clk),
    .rst       (rst),
    .req_valid (mode_req_valid),
    .req_mode  (mode_req),
    .mode_q    (shadow_active),
    .err_q     (mode_err),
    .next_mode (next_mode),
    .req_bad   (req_bad)
  );

  // write steering: bank chosen by the mode live after this edge
  logic              wr_live, wr_shd, wr_main;
  logic [SLOT_W-1:0] wr_slot;

  always_comb begin
    wr_live = wr_en && !req_bad && (wr_addr != ZERO_REG);
    wr_shd  = wr_live && SHADOW_MASK[wr_addr] && next_mode;
    wr_main = wr_live && !wr_shd;
    wr_slot = SLOT_W'(srf_pkg::count_below(MASK_X, int'(wr_addr)));
  end

  // read address mapping per port
  logic [ADDR_W-1:0] rd_addr  [NRD];
  logic [SLOT_W-1:0] rd_slot  [NRD];
  logic [DATA_W-1:0] main_q   [NRD];
  logic [DATA_W-1:0] shd_q    [NRD];
  logic [DATA_W-1:0] rd_data  [NRD];
  logic              use_shd_q[NRD];
  logic              zero_q   [NRD];

  assign rd_addr[0] = rd_addr_a;
  assign rd_addr[1] = rd_addr_b;

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    always_comb begin
      rd_slot[p] = SLOT_W'(srf_pkg::count_below(MASK_X, int'(rd_addr[p])));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        use_shd_q[p] <= 1'b0;
        zero_q[p]    <= 1'b0;
      end else begin
        use_shd_q[p] <= SHADOW_MASK[rd_addr[p]] && shadow_active;
        zero_q[p]    <= (rd_addr[p] == ZERO_REG);
      end
    end

    always_comb begin
      if (zero_q[p])         rd_data[p] = '0;
      else if (use_shd_q[p]) rd_data[p] = shd_q[p];
      else                   rd_data[p] = main_q[p];
    end
  end

  assign rd_data_a = rd_data[0];
  assign rd_data_b = rd_data[1];

  // storage: one entry per register, plus one per shadowed register
  srf_bank #(.DEPTH(NREG), .DATA_W(DATA_W), .AW(ADDR_W)) u_main (
    .clk     (clk),
    .we      (wr_main),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .raddr_a (rd_addr[0]),
    .raddr_b (rd_addr[1]),
    .rdata_a (main_q[0]),
    .rdata_b (main_q[1])
  );

  srf_bank #(.DEPTH(NSHD), .DATA_W(DATA_W), .AW(SLOT_W)) u_shadow (
    .clk     (clk),
    .we      (wr_shd),
    .waddr   (wr_slot),
    .wdata   (wr_data),
    .raddr_a (rd_slot[0]),
    .raddr_b (rd_slot[1]),
    .rdata_a (shd_q[0]),
    .rdata_b (shd_q[1])
  );

endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b,
  input logic              mode_req_valid,
  input logic              mode_req,
  input logic              shadow_active,
  input logic              mode_err
);

  localparam logic [ADDR_W-1:0] TOP_REG = '1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (shadow_active && !mode_err));

  // R8
  bad_req_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_req_valid && (mode_req == shadow_active)) |=>
      (mode_err && (shadow_active == $past(shadow_active))));

  // R6
  mode_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_req_valid && (mode_req != shadow_active)) |=>
      ((shadow_active == $past(mode_req)) && !mode_err));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_req_valid |=> ($stable(shadow_active) && !mode_err));

  // R10
  zero_reg_a_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == TOP_REG) |=> (rd_data_a == '0));

  // R10
  zero_reg_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == TOP_REG) |=> (rd_data_b == '0));

endmodule

bind shadow_regfile srf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .rd_addr_a      (rd_addr_a),
  .rd_data_a      (rd_data_a),
  .rd_addr_b      (rd_addr_b),
  .rd_data_b      (rd_data_b),
  .mode_req_valid (mode_req_valid),
  .mode_req       (mode_req),
  .shadow_active  (shadow_active),
  .mode_err       (mode_err)
);

// File: tb/tb_shadow_regfile.sv
module tb_shadow_regfile;

  localparam int CLK_P = 10;
  localparam int NPROBE = 10;
  // {banked, register number}
  localparam logic [5:0] PROBES [NPROBE] = '{
    {1'b0, 5'd0},  {1'b0, 5'd7},  {1'b1, 5'd8},  {1'b1, 5'd11},
    {1'b1, 5'd14}, {1'b0, 5'd15}, {1'b0, 5'd24}, {1'b1, 5'd25},
    {1'b0, 5'd26}, {1'b0, 5'd31}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [63:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0, mode_req_valid = 1'b0, mode_req = 1'b0;
  logic        shadow_active, mode_err;
  int          n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  shadow_regfile dut (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_req_valid(mode_req_valid), .mode_req(mode_req),
    .shadow_active(shadow_active), .mode_err(mode_err)
  );

  function automatic logic [63:0] val_s(input int r);
    return {32'h5AD0_0000, 24'h0, 8'(r)};
  endfunction

  function automatic logic [63:0] val_n(input int r);
    return {32'h0123_0000, 24'h0, 8'(r)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, return just after the next rising edge
  task automatic step(input logic we, input logic [4:0] wa, input logic [63:0] wd,
                      input logic rv, input logic rm,
                      input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    mode_req_valid = rv; mode_req = rm;
    rd_addr_a = ra; rd_addr_b = rb;
    @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic probe_all(input logic mode);
    for (int i = 0; i < NPROBE; i++) begin
      logic [4:0]  r;
      logic [63:0] exp;
      r = PROBES[i][4:0];
      if (r == 5'd31)                 exp = '0;
      else if (PROBES[i][5] && mode) exp = val_s(int'(r));
      else                            exp = val_n(int'(r));
      step(1'b0, 5'd0, '0, 1'b0, 1'b0, r, r);
      chk($sformatf("R3/R4/R5/R10 port A reg %0d mode %0d", r, mode), rd_data_a, exp);
      chk($sformatf("R3/R4/R5/R10 port B reg %0d mode %0d", r, mode), rd_data_b, exp);
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 50000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 shadow_active after reset", 64'(shadow_active), 64'd1);
    chk("R1 mode_err after reset", 64'(mode_err), 64'd0);

    // shadow copies get val_s (reset state is shadow mode)
    for (int r = 0; r < 32; r++) step(1'b1, 5'(r), val_s(r), 1'b0, 1'b0, 5'd0, 5'd0);
    step(1'b0, 5'd0, '0, 1'b1, 1'b0, 5'd0, 5'd0);
    chk("R5 leave shadow", 64'(shadow_active), 64'd0);
    chk("R8 no error on legal leave", 64'(mode_err), 64'd0);
    for (int r = 0; r < 32; r++) step(1'b1, 5'(r), val_n(r), 1'b0, 1'b0, 5'd0, 5'd0);

    probe_all(1'b0);
    step(1'b0, 5'd0, '0, 1'b1, 1'b1, 5'd0, 5'd0);
    chk("R5 enter shadow", 64'(shadow_active), 64'd1);
    probe_all(1'b1);
    step(1'b0, 5'd0, '0, 1'b1, 1'b0, 5'd0, 5'd0);
    probe_all(1'b0);

    // R6: read on the switching edge sees the old mapping
    step(1'b0, 5'd0, '0, 1'b1, 1'b1, 5'd9, 5'd25);
    chk("R6 read on switch edge A", rd_data_a, val_n(9));
    chk("R6 read on switch edge B", rd_data_b, val_n(25));
    chk("R6 mode updated", 64'(shadow_active), 64'd1);
    step(1'b0, 5'd0, '0, 1'b0, 1'b0, 5'd9, 5'd25);
    chk("R6 read after switch A", rd_data_a, val_s(9));
    chk("R6 read after switch B", rd_data_b, val_s(25));

    // R8/R9: illegal enter while in shadow, with a write alongside
    step(1'b1, 5'd9, 64'hDEAD_BEEF_0000_0009, 1'b1, 1'b1, 5'd9, 5'd9);
    chk("R8 mode_err raised", 64'(mode_err), 64'd1);
    chk("R8 mode unchanged", 64'(shadow_active), 64'd1);
    step(1'b0, 5'd0, '0, 1'b0, 1'b0, 5'd9, 5'd9);
    chk("R8 mode_err one cycle", 64'(mode_err), 64'd0);
    chk("R9 write dropped", rd_data_a, val_s(9));

    // R7: write in the switching cycle goes to the new live copy
    step(1'b1, 5'd10, 64'hC0DE_0000_0000_0010, 1'b1, 1'b0, 5'd0, 5'd0);
    chk("R7 left shadow", 64'(shadow_active), 64'd0);
    step(1'b0, 5'd0, '0, 1'b0, 1'b0, 5'd10, 5'd10);
    chk("R7 normal copy written", rd_data_a, 64'hC0DE_0000_0000_0010);
    step(1'b0, 5'd0, '0, 1'b1, 1'b1, 5'd0, 5'd0);
    step(1'b0, 5'd0, '0, 1'b0, 1'b0, 5'd10, 5'd10);
    chk("R7 shadow copy untouched", rd_data_b, val_s(10));
    step(1'b0, 5'd0, '0, 1'b1, 1'b0, 5'd0, 5'd0);

    // R8: illegal leave while normal
    step(1'b0, 5'd0, '0, 1'b1, 1'b0, 5'd0, 5'd0);
    chk("R8 mode_err on illegal leave", 64'(mode_err), 64'd1);
    chk("R8 mode stays normal", 64'(shadow_active), 64'd0);

    // R2: read-during-write returns the old value
    step(1'b1, 5'd5, 64'h0000_FEED_0000_0005, 1'b0, 1'b0, 5'd5, 5'd5);
    chk("R2 read-first port A", rd_data_a, val_n(5));
    chk("R2 read-first port B", rd_data_b, val_n(5));
    step(1'b0, 5'd0, '0, 1'b0, 1'b0, 5'd5, 5'd31);
    chk("R2 new value port A", rd_data_a, 64'h0000_FEED_0000_0005);
    chk("R10 port B zero", rd_data_b, 64'd0);

    summary();
    $finish;
  end

endmodule